// File: doc/BRIEF.md
# Single-Accumulator Fetch-Execute Sequencer

This block is the control sequencer and datapath of a small machine built around one 16-bit accumulator. It runs a fixed register-transfer loop. The program counter goes to the memory address register, and the addressed word comes back through the memory buffer register into the instruction register. The program counter then steps past the instruction, and the instruction executes. Each instruction is a single word, with a 4-bit operation code at the top and a 12-bit operand address below it.

Memory sits outside the block. It is a synchronous word-addressed store. A read strobe returns data one cycle later, and a write commits on the edge at which the write strobe is high. Data read from memory always lands in the buffer register before it reaches the instruction register or the accumulator.

The block also has a word input port, which stalls the machine until data is offered, and a word output port, which marks each emitted value with a one-cycle valid pulse. The subroutine call writes its return address straight into the called location. It then continues one word past that location and leaves the accumulator alone.

Top module: `acc_cpu`

## Requirements
- R1: While reset is low, and after it is released, `halted`, `mem_rd`, `mem_wr`, `out_valid` and `in_ready` are 0. The first instruction fetch reads address 0.
- R2: Each instruction is fetched as follows. A read strobe is raised at the program counter's address, and the returned word is taken one cycle later. The program counter then advances by one, so the following instruction comes from the next address.
- R3: An instruction word holds the operation in bits 15..12 and the operand address in bits 11..0. The codes are:
  - 0: call
  - 1: load
  - 2: store
  - 3: add
  - 4: subtract
  - 5: input
  - 6: output
  - 7: halt
  - 8: conditional skip
  - 9: jump
  - A: clear
- R4: Load copies the memory word at the operand address into the accumulator. Add and subtract combine the accumulator with that word in 16-bit two's complement, wrapping on overflow.
- R5: Store writes the accumulator to the operand address.
- R6: Conditional skip tests the accumulator using bits 11..10. Code 00 skips when it is negative, 01 when it is zero and 10 when it is positive (non-zero, sign clear). Code 11 never skips. A skip passes over exactly one instruction.
- R7: Jump continues execution at the operand address.
- R8: Call to address X writes the address of the instruction after the call into X. Execution then continues at X+1, and the accumulator is unchanged.
- R9: Clear sets the accumulator to zero.
- R10: Input holds `in_ready` high and waits for as long as `in_valid` stays low. On the first cycle that `in_valid` is high, it loads `in_data` into the accumulator.
- R11: Output raises `out_valid` for exactly one cycle, with `out_data` equal to the accumulator.
- R12: Halt raises `halted`, which stays high until reset. From then on no memory strobe is raised.
- R13: Halt, input, output, skip, jump, clear and the unused codes B..F make no memory access beyond their own fetch. The unused codes act as no-operations, and read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | 12 | Memory word address (memory address register) |
| mem_rd | output | 1 | Read strobe; data returns on `mem_rdata` the next cycle |
| mem_wr | output | 1 | Write strobe; commits `mem_wdata` at this edge |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data from memory |
| in_data | input | 16 | Input port word |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Sequencer is waiting on the input port |
| out_data | output | 16 | Output port word (accumulator) |
| out_valid | output | 1 | One-cycle pulse marking an output word |
| halted | output | 1 | Machine has stopped |

## Verification
The bench drives values across the sign and carry boundaries of add and subtract. A design that dropped the wrap, or mixed up the order of the operands, would store the wrong word. It tests every skip condition on both sides, including zero under the positive test. If zero were treated as positive, or the never-skip code did skip, the marker output would appear or vanish. It runs a call followed by outputs of the accumulator and then a jump over a trap output. A call that routed through the accumulator, or stored the call's own address, would show up in the output log or in the stored return word. The input stall, the fetch-only access counts and the quiet halt are checked by counting strobes. A design that touched memory for register-only instructions, or kept running after halt, would show extra counts.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int WORD_W = 16;
  localparam int OP_W   = 4;
  localparam int ADDR_W = WORD_W - OP_W;
  localparam int COND_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_CALL   = 4'h0,
    OP_LOAD   = 4'h1,
    OP_STORE  = 4'h2,
    OP_ADD    = 4'h3,
    OP_SUB    = 4'h4,
    OP_INPUT  = 4'h5,
    OP_OUTPUT = 4'h6,
    OP_HALT   = 4'h7,
    OP_SKIP   = 4'h8,
    OP_JUMP   = 4'h9,
    OP_CLEAR  = 4'hA
  } opcode_e;

  typedef enum logic [3:0] {
    ST_F_MAR,
    ST_F_RD,
    ST_F_MBR,
    ST_F_IR,
    ST_INC,
    ST_DEC,
    ST_M_RD,
    ST_M_MBR,
    ST_M_EXE,
    ST_S_MBR,
    ST_S_WR,
    ST_C_WR,
    ST_C_PC,
    ST_IN,
    ST_HALT
  } seq_state_e;

  typedef enum logic [2:0] {
    AC_FROM_MBR,
    AC_FROM_SUM,
    AC_FROM_DIFF,
    AC_FROM_ZERO,
    AC_FROM_PORT
  } ac_src_e;

  typedef struct packed {
    logic    mar_from_pc;
    logic    mar_from_ir;
    logic    mbr_from_mem;
    logic    mbr_from_ac;
    logic    ir_ld;
    logic    pc_step;
    logic    pc_from_ir;
    logic    pc_from_mar;
    logic    ac_ld;
    ac_src_e ac_src;
    logic    rd;
    logic    wr;
    logic    wdata_pc;
    logic    out_pulse;
    logic    in_wait;
    logic    stop;
  } ctl_t;

endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
(
  input  logic [WORD_W-1:0] ac_i,
  input  logic [WORD_W-1:0] mbr_i,
  input  logic [COND_W-1:0] cond_i,
  output logic [WORD_W-1:0] sum_o,
  output logic [WORD_W-1:0] diff_o,
  output logic              skip_o
);
  logic neg, zero;

  assign sum_o  = ac_i + mbr_i;
  assign diff_o = ac_i - mbr_i;
  assign neg    = ac_i[WORD_W-1];
  assign zero   = (ac_i == '0);

  always_comb begin
    unique case (cond_i)
      2'b00:   skip_o = neg;
      2'b01:   skip_o = zero;
      2'b10:   skip_o = !neg && !zero;
      default: skip_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_cpu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode_i,
  input  logic            skip_i,
  input  logic            in_valid_i,
  output ctl_t            ctl_o
);
  seq_state_e state_q, state_d;
  opcode_e    op;

  assign op = opcode_e'(opcode_i);

  always_comb begin
    state_d = state_q;
    ctl_o   = '0;
    unique case (state_q)
      ST_F_MAR: begin ctl_o.mar_from_pc  = 1'b1; state_d = ST_F_RD;  end
      ST_F_RD:  begin ctl_o.rd           = 1'b1; state_d = ST_F_MBR; end
      ST_F_MBR: begin ctl_o.mbr_from_mem = 1'b1; state_d = ST_F_IR;  end
      ST_F_IR:  begin ctl_o.ir_ld        = 1'b1; state_d = ST_INC;   end
      ST_INC:   begin ctl_o.pc_step      = 1'b1; state_d = ST_DEC;   end
      ST_DEC: begin
        state_d = ST_F_MAR;
        case (op)
          OP_CALL:  begin ctl_o.mar_from_ir = 1'b1; state_d = ST_C_WR; end
          OP_LOAD, OP_ADD, OP_SUB:
                    begin ctl_o.mar_from_ir = 1'b1; state_d = ST_M_RD; end
          OP_STORE: begin ctl_o.mar_from_ir = 1'b1; state_d = ST_S_MBR; end
          OP_INPUT:  state_d = ST_IN;
          OP_OUTPUT: ctl_o.out_pulse = 1'b1;
          OP_HALT:   state_d = ST_HALT;
          OP_SKIP:   ctl_o.pc_step = skip_i;
          OP_JUMP:   ctl_o.pc_from_ir = 1'b1;
          OP_CLEAR:  begin ctl_o.ac_ld = 1'b1; ctl_o.ac_src = AC_FROM_ZERO; end
          default:   state_d = ST_F_MAR;
        endcase
      end
      ST_M_RD:  begin ctl_o.rd           = 1'b1; state_d = ST_M_MBR; end
      ST_M_MBR: begin ctl_o.mbr_from_mem = 1'b1; state_d = ST_M_EXE; end
      ST_M_EXE: begin
        ctl_o.ac_ld  = 1'b1;
        ctl_o.ac_src = (op == OP_ADD) ? AC_FROM_SUM :
                       (op == OP_SUB) ? AC_FROM_DIFF : AC_FROM_MBR;
        state_d = ST_F_MAR;
      end
      ST_S_MBR: begin ctl_o.mbr_from_ac = 1'b1; state_d = ST_S_WR; end
      ST_S_WR:  begin ctl_o.wr = 1'b1; state_d = ST_F_MAR; end
      ST_C_WR:  begin ctl_o.wr = 1'b1; ctl_o.wdata_pc = 1'b1; state_d = ST_C_PC; end
      ST_C_PC:  begin ctl_o.pc_from_mar = 1'b1; state_d = ST_F_MAR; end
      ST_IN: begin
        ctl_o.in_wait = 1'b1;
        if (in_valid_i) begin
          ctl_o.ac_ld  = 1'b1;
          ctl_o.ac_src = AC_FROM_PORT;
          state_d      = ST_F_MAR;
        end
      end
      ST_HALT:  ctl_o.stop = 1'b1;
      default:  state_d = ST_F_MAR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_F_MAR;
    else        state_q <= state_d;
  end

  // R2: a fetch read is always followed by the buffer capture
  p_fetch_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_F_RD) |=> ctl_o.mbr_from_mem);
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  output logic              halted
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic              rst_s;
  ctl_t              ctl;
  logic [ADDR_W-1:0] pc_q, pc_d, mar_q, mar_d;
  logic [WORD_W-1:0] mbr_q, mbr_d, ir_q, ir_d, ac_q, ac_d;
  logic              pc_en, mar_en, mbr_en, ir_en, ac_en;
  logic [WORD_W-1:0] sum, diff;
  logic              skip;

  acc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s));

  acc_alu u_alu (
    .ac_i(ac_q), .mbr_i(mbr_q), .cond_i(ir_q[ADDR_W-1 -: COND_W]),
    .sum_o(sum), .diff_o(diff), .skip_o(skip)
  );

  acc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_s), .opcode_i(ir_q[WORD_W-1 -: OP_W]),
    .skip_i(skip), .in_valid_i(in_valid), .ctl_o(ctl)
  );

  // next-state values and clock enables
  always_comb begin
    pc_en  = ctl.pc_step | ctl.pc_from_ir | ctl.pc_from_mar;
    mar_en = ctl.mar_from_pc | ctl.mar_from_ir;
    mbr_en = ctl.mbr_from_mem | ctl.mbr_from_ac;
    ir_en  = ctl.ir_ld;
    ac_en  = ctl.ac_ld;

    pc_d = pc_q + ADDR_ONE;
    if (ctl.pc_from_ir)  pc_d = ir_q[ADDR_W-1:0];
    if (ctl.pc_from_mar) pc_d = mar_q + ADDR_ONE;

    mar_d = ctl.mar_from_ir ? ir_q[ADDR_W-1:0] : pc_q;
    mbr_d = ctl.mbr_from_ac ? ac_q : mem_rdata;
    ir_d  = mbr_q;

    unique case (ctl.ac_src)
      AC_FROM_SUM:  ac_d = sum;
      AC_FROM_DIFF: ac_d = diff;
      AC_FROM_ZERO: ac_d = '0;
      AC_FROM_PORT: ac_d = in_data;
      default:      ac_d = mbr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pc_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      ac_q  <= '0;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (mar_en) mar_q <= mar_d;
      if (mbr_en) mbr_q <= mbr_d;
      if (ir_en)  ir_q  <= ir_d;
      if (ac_en)  ac_q  <= ac_d;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_rd    = ctl.rd;
  assign mem_wr    = ctl.wr;
  assign mem_wdata = ctl.wdata_pc ? {{(WORD_W-ADDR_W){1'b0}}, pc_q} : mbr_q;
  assign in_ready  = ctl.in_wait;
  assign out_data  = ac_q;
  assign out_valid = ctl.out_pulse;
  assign halted    = ctl.stop;

  // R2: every program counter step advances by exactly one word
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_s)
    ctl.pc_step |=> (pc_q == $past(pc_q) + ADDR_ONE));

  // R8: the call write leaves accumulator and buffer untouched
  p_call_keeps_regs_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (mem_wr && ctl.wdata_pc) |=> ($stable(ac_q) && $stable(mbr_q)));

  // R10: accumulator holds while the input port is empty
  p_in_wait_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (in_ready && !in_valid) |=> $stable(ac_q));

  // R11: output valid lasts one cycle
  p_out_pulse_r11: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid |=> !out_valid);

  // R12: halt is sticky and quiet
  p_halt_sticky_r12: assert property (@(posedge clk) disable iff (!rst_s)
    halted |=> halted);
  p_halt_quiet_r12: assert property (@(posedge clk) disable iff (!rst_s)
    halted |-> (!mem_rd && !mem_wr));

  // R13: never read and write together
  p_one_strobe_r13: assert property (@(posedge clk) disable iff (!rst_s)
    !(mem_rd && mem_wr));
endmodule

// File: tb/acc_cpu_test.sv
module acc_cpu_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [15:0] in_data;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] out_data;
  logic        out_valid;
  logic        halted;

  int errors = 0;
  int checks = 0;

  logic [15:0] mem [256];
  logic        ld_en;
  logic [7:0]  ld_addr;
  logic [15:0] ld_data;

  int          out_count = 0, rd_count = 0, wr_count = 0;
  logic [15:0] out_log [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .halted(halted)
  );

  // memory model: one-cycle read, write on strobe edge; loader port for the bench
  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
  end

  // port monitor, away from the active edge
  always @(negedge clk) begin
    if (out_valid) begin
      out_log[out_count[2:0]] <= out_data;
      out_count <= out_count + 1;
    end
    if (mem_rd) rd_count <= rd_count + 1;
    if (mem_wr) wr_count <= wr_count + 1;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic start_prog();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) poke(8'(i), 16'h0000);
  endtask

  task automatic go();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_to_halt(input string req);
    int n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(req, {15'd0, halted}, 16'h0001);
  endtask

  typedef struct packed {
    logic [1:0]  kind;   // 0 add, 1 subtract, 2 skip
    logic [1:0]  cond;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] exp;    // result word, or 1 if skip expected
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 16'h0003, 16'h0004, 16'h0007},
    '{2'd0, 2'd0, 16'h7FFF, 16'h0001, 16'h8000},
    '{2'd0, 2'd0, 16'hFFFF, 16'h0001, 16'h0000},
    '{2'd1, 2'd0, 16'h0005, 16'h0007, 16'hFFFE},
    '{2'd1, 2'd0, 16'h8000, 16'h0001, 16'h7FFF},
    '{2'd2, 2'd0, 16'h8000, 16'h0000, 16'h0001},
    '{2'd2, 2'd0, 16'h0001, 16'h0000, 16'h0000},
    '{2'd2, 2'd1, 16'h0000, 16'h0000, 16'h0001},
    '{2'd2, 2'd1, 16'h0005, 16'h0000, 16'h0000},
    '{2'd2, 2'd2, 16'h0001, 16'h0000, 16'h0001},
    '{2'd2, 2'd2, 16'h0000, 16'h0000, 16'h0000},
    '{2'd2, 2'd3, 16'hFFFF, 16'h0000, 16'h0000}
  };

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base_o, base_r, base_w, n;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    ld_en = 1'b0; ld_addr = '0; ld_data = '0;

    // ---- vector table: arithmetic (R4 R5 R11) and skip conditions (R6)
    for (int v = 0; v < NV; v++) begin
      start_prog();
      poke(8'h80, VECS[v].a);
      poke(8'h81, VECS[v].b);
      poke(8'h00, 16'h1080);                         // load 0x80
      if (VECS[v].kind == 2'd2) begin
        poke(8'h01, 16'h8000 | (16'(VECS[v].cond) << 10)); // skip
        poke(8'h02, 16'h6000);                       // output (marker)
        poke(8'h03, 16'h7000);                       // halt
      end else begin
        poke(8'h01, (VECS[v].kind == 2'd0) ? 16'h3081 : 16'h4081);
        poke(8'h02, 16'h2082);                       // store 0x82
        poke(8'h03, 16'h6000);                       // output
        poke(8'h04, 16'h7000);                       // halt
      end
      base_o = out_count;
      go();
      run_to_halt("R12 halt reached");
      if (VECS[v].kind == 2'd2) begin
        // R6: skipped marker means no output
        chk("R6 skip decision", 16'(out_count - base_o), VECS[v].exp ^ 16'h0001);
      end else begin
        chk("R4 R5 stored result", mem[8'h82], VECS[v].exp);
        chk("R11 output value", out_log[base_o[2:0]], VECS[v].exp);
        chk("R11 one pulse", 16'(out_count - base_o), 16'h0001);
      end
    end

    // ---- R1: reset state and first fetch address
    start_prog();
    poke(8'h00, 16'h7000);
    @(negedge clk);
    chk("R1 outputs in reset", {11'd0, halted, mem_rd, mem_wr, out_valid, in_ready}, 16'h0000);
    go();
    chk("R1 outputs after release", {11'd0, halted, mem_rd, mem_wr, out_valid, in_ready}, 16'h0000);
    n = 0;
    while (!mem_rd && n < 50) begin @(negedge clk); n++; end
    chk("R1 R2 first fetch address", {4'd0, mem_addr}, 16'h0000);
    run_to_halt("R12 halt at address 0");

    // ---- R12: halt is sticky and quiet
    base_r = rd_count; base_w = wr_count;
    repeat (20) @(negedge clk);
    chk("R12 halted stays", {15'd0, halted}, 16'h0001);
    chk("R12 no strobes after halt", 16'((rd_count - base_r) + (wr_count - base_w)), 16'h0000);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears halted", {15'd0, halted}, 16'h0000);

    // ---- R8 call, R9 clear, R7 jump, R3 encodings
    start_prog();
    poke(8'h80, 16'h1234);
    poke(8'h00, 16'h1080);   // load 0x80
    poke(8'h01, 16'h0010);   // call 0x10
    poke(8'h10, 16'hDEAD);
    poke(8'h11, 16'h6000);   // output
    poke(8'h12, 16'hA000);   // clear
    poke(8'h13, 16'h6000);   // output
    poke(8'h14, 16'h9020);   // jump 0x20
    poke(8'h15, 16'h6000);   // trap output
    poke(8'h20, 16'h7000);   // halt
    base_o = out_count;
    go();
    run_to_halt("R7 halt at jump target");
    chk("R8 return address stored", mem[8'h10], 16'h0002);
    chk("R8 accumulator kept", out_log[base_o[2:0]], 16'h1234);
    chk("R9 clear", out_log[3'(base_o + 1)], 16'h0000);
    chk("R7 jump skipped trap", 16'(out_count - base_o), 16'h0002);

    // ---- R10: input stall and load
    start_prog();
    poke(8'h00, 16'h5000);   // input
    poke(8'h01, 16'h6000);   // output
    poke(8'h02, 16'h7000);   // halt
    base_o = out_count;
    go();
    repeat (30) @(negedge clk);
    chk("R10 ready while waiting", {15'd0, in_ready}, 16'h0001);
    chk("R10 stalled", {15'd0, halted}, 16'h0000);
    chk("R10 no output yet", 16'(out_count - base_o), 16'h0000);
    in_data = 16'hBEEF; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_data = 16'h0000;
    run_to_halt("R10 resumes");
    chk("R10 loaded word", out_log[base_o[2:0]], 16'hBEEF);
    chk("R10 ready dropped", {15'd0, in_ready}, 16'h0000);

    // ---- R13: register-only instructions touch memory only to fetch
    start_prog();
    poke(8'h90, 16'h5555);
    poke(8'h00, 16'hA000);   // clear
    poke(8'h01, 16'h8400);   // skip if zero
    poke(8'h02, 16'h2090);   // store (skipped)
    poke(8'h03, 16'h6000);   // output
    poke(8'h04, 16'h9006);   // jump 6
    poke(8'h05, 16'h6000);   // not reached
    poke(8'h06, 16'hB000);   // unused code: no-op
    poke(8'h07, 16'h7000);   // halt
    @(negedge clk);
    base_o = out_count; base_r = rd_count; base_w = wr_count;
    go();
    run_to_halt("R13 halt reached");
    chk("R13 reads are fetches only", 16'(rd_count - base_r), 16'h0006);
    chk("R13 no writes", 16'(wr_count - base_w), 16'h0000);
    chk("R13 R6 skipped store", mem[8'h90], 16'h5555);
    chk("R13 one output", 16'(out_count - base_o), 16'h0001);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule